// File: doc/BRIEF.md
# Sparse-Skipping Blocked Matrix-Vector Multiplier

This block forms the gradient vector y = A·x − b for a square problem of dimension N, using signed fixed-point arithmetic. The matrix is not stored locally. It arrives on a valid/ready stream, and each beat carries M elements. Each beat is one column slice of a group of M rows: lane i holds A[g·M+i][c]. Column-serial slices are used because the local x and b buffers provide only one read per cycle. One x value therefore serves all M row accumulators in a beat.

Two masks, one per dimension, mark which rows and columns are active. They are sampled when `start` is accepted.
- A group of M rows with no active row is skipped completely. It requests no stream data and writes no outputs.
- A group of M columns with no active column is never requested.
- Inside a processed column group, an inactive column is still streamed, but its x value is replaced by zero before accumulation.

After the last column group of a row group, the M accumulators are written out one per cycle, each with its b entry subtracted. Before a run, x and b are loaded through a small write port. A one-cycle `done` pulse ends the run.

Top module: `mvskip_top`

## Requirements
- R1: For every row r that is written, y_data equals the sum over active columns c of A[r][c]·x[c], minus b[r]. Elements are DW-bit two's complement values and the result is AW-bit two's complement. Each row group's accumulators start from zero.
- R2: A column whose mask bit is 0 but that lies in a processed column group is streamed, and it contributes exactly zero to every row.
- R3: A column group (columns g·M..g·M+M−1) whose mask bits are all 0 is never requested. The number of accepted beats equals (active row groups) × (active column groups) × M.
- R4: A row group whose mask bits are all 0 requests no beats and produces no write strobe for any of its rows.
- R5: Beats are consumed in this order: active row groups ascending, then active column groups ascending, then columns ascending. Lane i (bits i·DW..i·DW+DW−1) of a beat is A[g·M+i][c]. A beat is consumed only on a cycle with `a_valid` and `a_ready` both high, so gaps in `a_valid` do not change the results.
- R6: Each processed row group writes exactly its M rows, in ascending `y_addr`, on consecutive cycles, one write per cycle.
- R7: A processed row group with no active column group requests no beats and writes −b[r] for each of its rows.
- R8: `row_act` and `col_act` are sampled in the cycle that accepts `start`. Changes to them later in the run have no effect on that run.
- R9: `done` is high for exactly one cycle. That cycle is the second cycle after the final write cycle. When no row group is active, it is the second cycle after the edge that samples `start`.
- R10: While reset is held, `done`, `y_we` and `a_ready` are low.
- R11: When `ld_we` is high, `ld_sel` = 0 writes x[ld_addr] and `ld_sel` = 1 writes b[ld_addr]. These writes take effect only while the block is idle, and are ignored during a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Vector buffer write enable |
| ld_sel | input | 1 | 0 selects x, 1 selects b |
| ld_addr | input | IW | Vector element index |
| ld_data | input | DW | Element value, signed |
| start | input | 1 | Begin a run (accepted while idle) |
| row_act | input | N | Active mask for rows |
| col_act | input | N | Active mask for columns |
| a_valid | input | 1 | Matrix beat valid |
| a_data | input | M*DW | Matrix beat, one element per lane |
| a_ready | output | 1 | Block accepts a matrix beat |
| y_we | output | 1 | Output buffer write strobe |
| y_addr | output | IW | Output row index |
| y_data | output | AW | Gradient entry, signed |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The embedded assertions check the following on every cycle:
- every write strobe targets a row group that has an active row;
- every request for a beat falls inside a live column group;
- writes within a group are strictly consecutive;
- a masked column leaves its accumulator unchanged;
- a cleared accumulator reads zero;
- `done` never lasts two cycles.

Some properties are shown only by the bench scenarios, by comparison with an independent model over several mask patterns:
- the gradient values themselves;
- the exact number of beats;
- the `done` latency;
- the insensitivity to `a_valid` gaps, to mask changes during a run, and to buffer writes during a run.

// File: rtl/mvskip_pkg.sv
package mvskip_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIND,
    ST_MAC,
    ST_WB,
    ST_DONE
  } mv_state_t;
endpackage

// File: rtl/mvskip_group_scan.sv
module mvskip_group_scan #(
  parameter int N = 8,
  parameter int M = 2,
  localparam int NG = N / M
) (
  input  logic [N-1:0]  mask,
  output logic [NG-1:0] grp_live
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_live[g] = |mask[g*M +: M];
  end
endmodule

// File: rtl/mvskip_lane.sv
module mvskip_lane #(
  parameter int DW = 16,
  parameter int AW = 37
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 col_en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] x,
  output logic signed [AW-1:0] acc
);
  function automatic logic signed [AW-1:0] mac_term(
    input logic signed [DW-1:0] ea,
    input logic signed [DW-1:0] ex,
    input logic keep
  );
    logic signed [2*DW-1:0] p;
    p = ea * ex;
    return keep ? {{(AW-2*DW){p[2*DW-1]}}, p} : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (en)     acc <= acc + mac_term(a, x, col_en);
  end

  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !col_en && !clr) |=> $stable(acc)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0)); // R1
endmodule

// File: rtl/mvskip_top.sv
module mvskip_top #(
  parameter int N  = 8,
  parameter int M  = 2,
  parameter int DW = 16,
  localparam int NG = N / M,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int GW = $clog2(NG + 1),
  localparam int AW = 2 * DW + IW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic            ld_sel,
  input  logic [IW-1:0]   ld_addr,
  input  logic [DW-1:0]   ld_data,
  input  logic            start,
  input  logic [N-1:0]    row_act,
  input  logic [N-1:0]    col_act,
  input  logic            a_valid,
  input  logic [M*DW-1:0] a_data,
  output logic            a_ready,
  output logic            y_we,
  output logic [IW-1:0]   y_addr,
  output logic [AW-1:0]   y_data,
  output logic            done
);
  import mvskip_pkg::*;

  function automatic logic [GW-1:0] next_grp(input logic [NG-1:0] v, input int from);
    logic [GW-1:0] r;
    r = GW'(NG);
    for (int g = NG - 1; g >= 0; g--)
      if (g >= from && v[g]) r = GW'(g);
    return r;
  endfunction

  function automatic logic signed [AW-1:0] grad(
    input logic signed [AW-1:0] s,
    input logic signed [DW-1:0] b
  );
    return s - {{(AW-DW){b[DW-1]}}, b};
  endfunction

  mv_state_t state;
  logic [N-1:0]  row_q, col_q;
  logic [NG-1:0] rga, cga;
  logic [GW-1:0] rg, cg;
  logic [IW-1:0] col, wb_k;
  logic signed [DW-1:0] xbuf [N];
  logic signed [DW-1:0] bbuf [N];
  logic signed [AW-1:0] acc [M];
  logic signed [AW-1:0] acc_sel;

  // named internal events
  logic          take, last_col, wb_last, lane_clr, col_keep;
  logic [GW-1:0] fr_row, fr_col0, nx_col;
  logic signed [DW-1:0] x_rd;

  mvskip_group_scan #(.N(N), .M(M)) u_rscan (.mask(row_q), .grp_live(rga));
  mvskip_group_scan #(.N(N), .M(M)) u_cscan (.mask(col_q), .grp_live(cga));

  assign a_ready  = (state == ST_MAC);
  assign take     = a_ready && a_valid;
  assign last_col = (int'(col) == int'(cg) * M + M - 1);
  assign wb_last  = (int'(wb_k) == M - 1);
  assign lane_clr = (state == ST_FIND);
  assign fr_row   = next_grp(rga, int'(rg));
  assign fr_col0  = next_grp(cga, 0);
  assign nx_col   = next_grp(cga, int'(cg) + 1);
  assign col_keep = col_q[col];
  assign x_rd     = xbuf[col];

  always_ff @(posedge clk) begin
    if (ld_we && state == ST_IDLE) begin
      if (ld_sel) bbuf[ld_addr] <= ld_data;
      else        xbuf[ld_addr] <= ld_data;
    end
  end

  for (genvar i = 0; i < M; i++) begin : g_lane
    mvskip_lane #(.DW(DW), .AW(AW)) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(lane_clr), .en(take), .col_en(col_keep),
      .a(a_data[i*DW +: DW]), .x(x_rd), .acc(acc[i]));
  end

  always_comb begin
    acc_sel = '0;
    for (int i = 0; i < M; i++)
      if (int'(wb_k) == i) acc_sel = acc[i];
  end

  assign y_we   = (state == ST_WB);
  assign y_addr = IW'(int'(rg) * M + int'(wb_k));
  assign y_data = grad(acc_sel, bbuf[y_addr]);
  assign done   = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
      rg    <= '0;
      cg    <= '0;
      col   <= '0;
      wb_k  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          row_q <= row_act;
          col_q <= col_act;
          rg    <= '0;
          state <= ST_FIND;
        end
        ST_FIND: begin
          wb_k <= '0;
          if (fr_row == GW'(NG)) state <= ST_DONE;
          else begin
            rg <= fr_row;
            if (fr_col0 == GW'(NG)) state <= ST_WB;
            else begin
              cg    <= fr_col0;
              col   <= IW'(int'(fr_col0) * M);
              state <= ST_MAC;
            end
          end
        end
        ST_MAC: if (take) begin
          if (last_col) begin
            if (nx_col == GW'(NG)) state <= ST_WB;
            else begin
              cg  <= nx_col;
              col <= IW'(int'(nx_col) * M);
            end
          end else col <= col + 1'b1;
        end
        ST_WB: begin
          wb_k <= wb_k + 1'b1;
          if (wb_last) begin
            rg    <= rg + 1'b1;
            state <= ST_FIND;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SKIP_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    y_we |-> rga[int'(y_addr) / M]); // R4
  AST_COL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    a_ready |-> cga[cg]); // R3
  AST_WB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (y_we && $past(y_we)) |-> (y_addr == IW'($past(y_addr) + 1'b1))); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: tb/test_mvskip_top.sv
`timescale 1ns/1ps
module test_mvskip_top;
  localparam int N = 8, M = 2, DW = 16, NG = N / M;
  localparam int IW = 3, AW = 2 * DW + IW + 2;
  // upper byte: row mask, lower byte: column mask
  localparam logic [15:0] VEC [6] = '{16'hFFFF, 16'h0FFF, 16'hFF3C,
                                      16'h5A81, 16'h3000, 16'h00FF};

  logic clk = 0, rst_n = 0;
  logic ld_we = 0, ld_sel = 0;
  logic [IW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic start = 0;
  logic [N-1:0] row_act = '0, col_act = '0;
  logic a_valid = 0;
  logic [M*DW-1:0] a_data = '0;
  logic a_ready, y_we, done;
  logic [IW-1:0] y_addr;
  logic [AW-1:0] y_data;

  mvskip_top #(.N(N), .M(M), .DW(DW)) i_mvskip_top (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .start(start), .row_act(row_act), .col_act(col_act),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready), .y_we(y_we),
    .y_addr(y_addr), .y_data(y_data), .done(done));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int pc = 0, nc = 0;
  int ch_r [64];
  int ch_c [64];
  int nch = 0, fi = 0, hs = 0;
  bit feed_on = 0;
  longint got [N];
  bit wr [N];
  int seq [N*4];
  int wcount = 0, lastw = 0, startc = 0, donec = 0, donen = 0;

  function automatic int a_el(int r, int c); return ((r * 3 + c * 5) % 11) - 5; endfunction
  function automatic int x_el(int c); return ((c * 7) % 9) - 4; endfunction
  function automatic int b_el(int r); return ((r * 13) % 17) - 8; endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    nc++;
    if (feed_on && fi < nch) begin
      a_valid = (nc % 3 != 1);
      for (int i = 0; i < M; i++)
        a_data[i*DW +: DW] = DW'(a_el(ch_r[fi] + i, ch_c[fi]));
    end else a_valid = 0;
  end

  always @(posedge clk) begin
    pc++;
    if (a_valid && a_ready) begin fi++; hs++; end
    if (y_we) begin
      got[y_addr] = longint'($signed(y_data));
      wr[y_addr] = 1;
      seq[wcount] = int'(y_addr);
      wcount++;
      lastw = pc;
    end
    if (start) startc = pc;
    if (done) begin donec = pc; donen++; end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic run_case(input logic [N-1:0] rm, input logic [N-1:0] cm, input bit perturb);
    longint expv [N];
    bit expw [N];
    int nwr = 0, t = 0;
    nch = 0; fi = 0; hs = 0; wcount = 0; donen = 0;
    for (int r = 0; r < N; r++) begin wr[r] = 0; got[r] = 0; end
    for (int g = 0; g < NG; g++) begin
      if (rm[g*M +: M] == '0) continue;
      for (int h = 0; h < NG; h++) begin
        if (cm[h*M +: M] == '0) continue;
        for (int j = 0; j < M; j++) begin ch_r[nch] = g * M; ch_c[nch] = h * M + j; nch++; end
      end
    end
    for (int r = 0; r < N; r++) begin
      expw[r] = (rm[(r/M)*M +: M] != '0);
      expv[r] = -b_el(r);
      for (int c = 0; c < N; c++) if (cm[c]) expv[r] += a_el(r, c) * x_el(c);
      if (expw[r]) nwr++;
    end
    feed_on = 1;
    @(negedge clk); row_act = rm; col_act = cm; start = 1;
    @(negedge clk); start = 0;
    if (perturb) begin
      row_act = '1; col_act = 8'h0F;
      ld_we = 1; ld_sel = 0; ld_addr = 3'd7; ld_data = 16'd1000;
      @(negedge clk); ld_we = 0;
    end
    while (donen == 0 && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    feed_on = 0;
    chk(donen == 1, "R9 done width", donen, 1);
    if (nwr == 0) chk(donec - startc == 2, "R9 latency from start", donec - startc, 2);
    else          chk(donec - lastw == 2, "R9 latency from last write", donec - lastw, 2);
    chk(hs == nch, "R3/R4 beat count", hs, nch);
    chk(wcount == nwr, "R4/R6 write count", wcount, nwr);
    for (int k = 1; k < wcount; k++)
      chk(seq[k] > seq[k-1], "R6 ascending rows", seq[k], seq[k-1] + 1);
    for (int r = 0; r < N; r++) begin
      chk(wr[r] == expw[r], "R4 row written", wr[r], expw[r]);
      if (expw[r]) chk(got[r] == expv[r], "R1/R2/R5/R7/R8 value", got[r], expv[r]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0, "R10 done in reset", done, 0);
    chk(y_we == 0, "R10 y_we in reset", y_we, 0);
    chk(a_ready == 0, "R10 a_ready in reset", a_ready, 0);
    rst_n = 1;
    // R11 load x (sel 0) and b (sel 1)
    for (int i = 0; i < N; i++) begin
      @(negedge clk); ld_we = 1; ld_sel = 0; ld_addr = IW'(i); ld_data = DW'(x_el(i));
      @(negedge clk); ld_sel = 1; ld_data = DW'(b_el(i));
    end
    @(negedge clk); ld_we = 0;
    // table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < 6; v++) run_case(VEC[v][15:8], VEC[v][7:0], 0);
    // R8 and R11: mask change and x write during a run are ignored
    run_case(8'h03, 8'hFF, 1);
    // R11: x[7] unchanged afterwards
    run_case(8'hC0, 8'h80, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule